// File: doc/BRIEF.md
# H-Bridge Protection Supervisor

This block decides, cycle by cycle, whether an H-bridge may drive its load. Three fault sources reach it as synchronous digital flags: an overcurrent detector, a thermal trip and a supply-undervoltage comparator. It produces a single output-disable request for the gate drivers. It also produces an active-low fault indication, which reports only overcurrent events. The analog sensing itself lies outside the block.

An overcurrent is accepted as real only after the detector flag stays high for a set number of consecutive clock cycles. After that, one of two responses applies. In auto-retry mode the bridge is held off for a timed window of 2 ms, converted to cycles from a clock-frequency parameter, and is then released to test whether the short is still there. In latched mode the bridge stays off until the bridge controller brings it out of low-power standby, or until a power-on reset. A thermal trip or an undervoltage holds the bridge off only while its flag is high, and neither ever latches. A build variant without the mode-select input always latches.

Top module: `bridge_fault_mgr`

## Requirements
- R1: When the overcurrent flag has been sampled high on FILT_CYC consecutive rising edges while the bridge is enabled, `drive_off` goes to 1 and `fault_n` goes to 0 on that same edge.
- R2: In auto-retry mode (`retry_sel` = 1 at the moment of qualification), `drive_off` and the low `fault_n` hold for exactly RETRY_CYC = CLK_FREQ_HZ/1000*RETRY_MS cycles. After that, `drive_off` returns to 0 (if no thermal or undervoltage flag is high) and `fault_n` returns to 1.
- R3: In latched mode (`retry_sel` = 0 at qualification), the bridge stays disabled and `fault_n` stays 0 regardless of elapsed time. Entering standby does not clear it. The latch clears on the first edge that sees `standby` fall from 1 to 0.
- R4: A high `therm_flag` forces `drive_off` to 1 one edge later, without touching `fault_n`. The disable ends one edge after the flag drops.
- R5: A high `uv_flag` forces `drive_off` to 1 one edge later, without touching `fault_n`. The disable ends one edge after the flag drops.
- R6: Overcurrent pulses shorter than FILT_CYC cycles have no effect. Any low sample restarts the consecutive count.
- R7: In auto-retry mode, an overcurrent that qualifies again after re-enable (FILT_CYC fresh high samples) disables the bridge again with a full new timeout. There is no limit on the number of retries.
- R8: With HAS_RETRY_SEL = 0, `retry_sel` is ignored and every qualified overcurrent latches as in R3.
- R9: An active-low `por_n` asynchronously clears all fault state. While it is low, `drive_off` = 1 and `fault_n` = 1. On the first edge after release, the outputs follow the current flags.
- R10: The mode is sampled only at qualification. Changing `retry_sel` while a fault is latched does not release it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| ocp_flag | input | 1 | Synchronous overcurrent-detect flag |
| therm_flag | input | 1 | Thermal trip flag |
| uv_flag | input | 1 | Supply undervoltage flag |
| retry_sel | input | 1 | 1 = timed auto-retry, 0 = latch on overcurrent |
| standby | input | 1 | Low-power standby indication from bridge controller |
| drive_off | output | 1 | 1 = bridge outputs must be disabled |
| fault_n | output | 1 | Active-low overcurrent fault indication |

## Verification
Each result is due on a known edge. A thermal or undervoltage disable appears on the first edge that samples the flag. An overcurrent disable appears on the FILT_CYC-th consecutive high edge. A retry release comes exactly RETRY_CYC edges after entry, and a latch release comes on the edge that samples standby low after high. The bench drives inputs and samples outputs at falling edges. It advances by the exact count of rising edges, so it checks one cycle before each due edge (outputs unchanged) and again on the due edge. Re-qualification after a retry is checked at the same two points, once on each of several retries.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

    typedef enum logic [1:0] {
        OC_CLEAR   = 2'd0,
        OC_RETRY   = 2'd1,
        OC_LATCHED = 2'd2
    } oc_state_e;

endpackage

// File: rtl/bfm_glitch_filter.sv
module bfm_glitch_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic flag_i,
    input  logic clr_i,
    output logic qual_o
);
    localparam int CNT_W = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILT_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } filt_regs_t;

    filt_regs_t filt_d, filt_q;

    always_comb begin
        filt_d = filt_q;
        if (clr_i || !flag_i) begin
            filt_d.cnt = '0;
        end else if (filt_q.cnt != CNT_TOP) begin
            filt_d.cnt = filt_q.cnt + 1'b1;
        end
        qual_o = flag_i && !clr_i && (filt_q.cnt == CNT_TOP);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            filt_q <= '0;
        end else begin
            filt_q <= filt_d;
        end
    end

    AST_LOW_RESTARTS: assert property (@(posedge clk) disable iff (!por_n)
        !flag_i |=> (filt_q.cnt == '0)); // R6

endmodule

// File: rtl/bfm_ocp_ctrl.sv
module bfm_ocp_ctrl
    import bfm_pkg::*;
#(
    parameter int RETRY_CYC = 2000
) (
    input  logic clk,
    input  logic por_n,
    input  logic qual_i,
    input  logic latch_mode_i,
    input  logic standby_i,
    output logic block_o,
    output logic block_nxt_o
);
    localparam int TMR_W = $clog2(RETRY_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(RETRY_CYC - 1);

    typedef struct packed {
        oc_state_e        state;
        logic [TMR_W-1:0] timer;
        logic             stby;
    } ctrl_regs_t;

    ctrl_regs_t ctrl_d, ctrl_q;
    logic       stby_exit;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.stby = standby_i;
        stby_exit   = ctrl_q.stby && !standby_i;
        unique case (ctrl_q.state)
            OC_CLEAR: begin
                if (qual_i) begin
                    ctrl_d.state = latch_mode_i ? OC_LATCHED : OC_RETRY;
                    ctrl_d.timer = TMR_LOAD;
                end
            end
            OC_RETRY: begin
                if (ctrl_q.timer == '0) begin
                    ctrl_d.state = OC_CLEAR;
                end else begin
                    ctrl_d.timer = ctrl_q.timer - 1'b1;
                end
            end
            OC_LATCHED: begin
                if (stby_exit) begin
                    ctrl_d.state = OC_CLEAR;
                end
            end
            default: ctrl_d.state = OC_CLEAR;
        endcase
        block_o     = (ctrl_q.state != OC_CLEAR);
        block_nxt_o = (ctrl_d.state != OC_CLEAR);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctrl_q <= '{state: OC_CLEAR, timer: '0, stby: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_q.state == OC_LATCHED && !(ctrl_q.stby && !standby_i))
        |=> (ctrl_q.state == OC_LATCHED)); // R3
    AST_RETRY_WINDOW: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_q.state == OC_RETRY) |-> (ctrl_q.timer < TMR_W'(RETRY_CYC))); // R2
    AST_RETRY_ENDS: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_q.state == OC_RETRY && ctrl_q.timer == '0) |=> (ctrl_q.state == OC_CLEAR)); // R2
    AST_NO_UNQUALIFIED_TRIP: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_q.state == OC_CLEAR && !qual_i) |=> (ctrl_q.state == OC_CLEAR)); // R6

endmodule

// File: rtl/bridge_fault_mgr.sv
module bridge_fault_mgr #(
    parameter int CLK_FREQ_HZ   = 1_000_000,
    parameter int RETRY_MS      = 2,
    parameter int FILT_CYC      = 4,
    parameter bit HAS_RETRY_SEL = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic ocp_flag,
    input  logic therm_flag,
    input  logic uv_flag,
    input  logic retry_sel,
    input  logic standby,
    output logic drive_off,
    output logic fault_n
);
    localparam int RETRY_CYC = (CLK_FREQ_HZ / 1000) * RETRY_MS;

    typedef struct packed {
        logic off;
        logic flt_n;
    } out_regs_t;

    out_regs_t out_d, out_q;
    logic      latch_mode;
    logic      oc_block;
    logic      oc_block_nxt;
    logic      oc_qual;

    generate
        if (HAS_RETRY_SEL) begin : g_sel
            assign latch_mode = !retry_sel;
        end else begin : g_nosel
            logic unused_retry_sel;
            assign unused_retry_sel = retry_sel;
            assign latch_mode       = 1'b1;
        end
    endgenerate

    bfm_glitch_filter #(
        .FILT_CYC (FILT_CYC)
    ) i_filter (
        .clk    (clk),
        .por_n  (por_n),
        .flag_i (ocp_flag),
        .clr_i  (oc_block),
        .qual_o (oc_qual)
    );

    bfm_ocp_ctrl #(
        .RETRY_CYC (RETRY_CYC)
    ) i_ctrl (
        .clk          (clk),
        .por_n        (por_n),
        .qual_i       (oc_qual),
        .latch_mode_i (latch_mode),
        .standby_i    (standby),
        .block_o      (oc_block),
        .block_nxt_o  (oc_block_nxt)
    );

    always_comb begin
        out_d       = out_q;
        out_d.off   = oc_block_nxt || therm_flag || uv_flag;
        out_d.flt_n = !oc_block_nxt;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            out_q <= '{off: 1'b1, flt_n: 1'b1};
        end else begin
            out_q <= out_d;
        end
    end

    assign drive_off = out_q.off;
    assign fault_n   = out_q.flt_n;

    AST_THERM_OFF: assert property (@(posedge clk) disable iff (!por_n)
        therm_flag |=> drive_off); // R4
    AST_UV_OFF: assert property (@(posedge clk) disable iff (!por_n)
        uv_flag |=> drive_off); // R5
    AST_FAULT_MEANS_OFF: assert property (@(posedge clk) disable iff (!por_n)
        !fault_n |-> drive_off); // R1
    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        $fell(fault_n) |=> !fault_n); // R2

endmodule

// File: tb/test_bridge_fault_mgr.sv
`timescale 1ns/1ps
module test_bridge_fault_mgr;

    localparam int CLK_HZ = 100_000;
    localparam int FILT   = 4;
    localparam int RC     = CLK_HZ * 2 / 1000;

    logic clk = 1'b0;
    logic por_n, ocp_flag, therm_flag, uv_flag, retry_sel, standby;
    logic drive_off, fault_n, ns_drive_off, ns_fault_n;
    int   n_checks = 0;
    int   n_errors = 0;

    always #2 clk = ~clk;

    bridge_fault_mgr #(.CLK_FREQ_HZ(CLK_HZ), .RETRY_MS(2), .FILT_CYC(FILT), .HAS_RETRY_SEL(1'b1))
    i_bridge_fault_mgr (
        .clk(clk), .por_n(por_n), .ocp_flag(ocp_flag), .therm_flag(therm_flag),
        .uv_flag(uv_flag), .retry_sel(retry_sel), .standby(standby),
        .drive_off(drive_off), .fault_n(fault_n));

    bridge_fault_mgr #(.CLK_FREQ_HZ(CLK_HZ), .RETRY_MS(2), .FILT_CYC(FILT), .HAS_RETRY_SEL(1'b0))
    i_bridge_fault_mgr_nosel (
        .clk(clk), .por_n(por_n), .ocp_flag(ocp_flag), .therm_flag(therm_flag),
        .uv_flag(uv_flag), .retry_sel(retry_sel), .standby(standby),
        .drive_off(ns_drive_off), .fault_n(ns_fault_n));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic t_reset();
        por_n = 1'b0; ocp_flag = 0; therm_flag = 0; uv_flag = 0; retry_sel = 1; standby = 0;
        tick(3);
        chk("R9", "reset drive_off", drive_off, 1'b1);
        chk("R9", "reset fault_n", fault_n, 1'b1);
        por_n = 1'b1;
        tick(1);
        chk("R9", "post-reset drive_off", drive_off, 1'b0);
        chk("R9", "post-reset fault_n", fault_n, 1'b1);
    endtask

    task automatic t_thermal();
        therm_flag = 1'b1;
        tick(1);
        chk("R4", "therm drive_off", drive_off, 1'b1);
        chk("R4", "therm fault_n", fault_n, 1'b1);
        tick(5);
        chk("R4", "therm held", drive_off, 1'b1);
        therm_flag = 1'b0;
        tick(1);
        chk("R4", "therm release", drive_off, 1'b0);
    endtask

    task automatic t_uv();
        uv_flag = 1'b1;
        tick(1);
        chk("R5", "uv drive_off", drive_off, 1'b1);
        chk("R5", "uv fault_n", fault_n, 1'b1);
        uv_flag = 1'b0;
        tick(1);
        chk("R5", "uv release", drive_off, 1'b0);
    endtask

    task automatic t_glitch();
        ocp_flag = 1'b1; tick(FILT - 1);
        ocp_flag = 1'b0; tick(1);
        chk("R6", "short pulse drive_off", drive_off, 1'b0);
        ocp_flag = 1'b1; tick(FILT - 1);
        chk("R6", "restarted count drive_off", drive_off, 1'b0);
        ocp_flag = 1'b0; tick(1);
        chk("R6", "glitch fault_n", fault_n, 1'b1);
    endtask

    task automatic t_retry();
        retry_sel = 1'b1;
        ocp_flag  = 1'b1;
        tick(FILT - 1);
        chk("R1", "before qualify drive_off", drive_off, 1'b0);
        tick(1);
        chk("R1", "qualify drive_off", drive_off, 1'b1);
        chk("R1", "qualify fault_n", fault_n, 1'b0);
        ocp_flag = 1'b0;
        tick(RC - 1);
        chk("R2", "last retry cycle drive_off", drive_off, 1'b1);
        chk("R2", "last retry cycle fault_n", fault_n, 1'b0);
        tick(1);
        chk("R2", "re-enable drive_off", drive_off, 1'b0);
        chk("R2", "re-enable fault_n", fault_n, 1'b1);
    endtask

    task automatic t_requal();
        retry_sel = 1'b1;
        ocp_flag  = 1'b1;
        tick(FILT);
        chk("R7", "first trip", drive_off, 1'b1);
        for (int k = 0; k < 3; k++) begin
            tick(RC);
            chk("R7", "retry release", drive_off, 1'b0);
            tick(FILT - 1);
            chk("R7", "refilter window", drive_off, 1'b0);
            tick(1);
            chk("R7", "retrip drive_off", drive_off, 1'b1);
            chk("R7", "retrip fault_n", fault_n, 1'b0);
        end
        ocp_flag = 1'b0;
        tick(RC + 1);
        chk("R7", "final release", drive_off, 1'b0);
    endtask

    task automatic t_latch();
        retry_sel = 1'b0;
        ocp_flag  = 1'b1;
        tick(FILT);
        chk("R3", "latch trip drive_off", drive_off, 1'b1);
        chk("R3", "latch trip fault_n", fault_n, 1'b0);
        ocp_flag  = 1'b0;
        retry_sel = 1'b1;
        tick(RC + 20);
        chk("R10", "mode change ignored", drive_off, 1'b1);
        chk("R3", "latch after timeout fault_n", fault_n, 1'b0);
        standby = 1'b1;
        tick(3);
        chk("R3", "standby entry keeps latch", drive_off, 1'b1);
        standby = 1'b0;
        tick(1);
        chk("R3", "standby exit drive_off", drive_off, 1'b0);
        chk("R3", "standby exit fault_n", fault_n, 1'b1);
    endtask

    task automatic t_por_clear();
        retry_sel = 1'b0;
        ocp_flag  = 1'b1;
        tick(FILT);
        chk("R9", "latched before por", fault_n, 1'b0);
        ocp_flag = 1'b0;
        tick(2);
        por_n = 1'b0;
        #1;
        chk("R9", "por async fault_n", fault_n, 1'b1);
        chk("R9", "por async drive_off", drive_off, 1'b1);
        tick(1);
        por_n = 1'b1;
        tick(1);
        chk("R9", "por cleared drive_off", drive_off, 1'b0);
    endtask

    task automatic t_nosel();
        retry_sel = 1'b1;
        ocp_flag  = 1'b1;
        tick(FILT);
        chk("R8", "nosel trip", ns_drive_off, 1'b1);
        ocp_flag = 1'b0;
        tick(RC + 5);
        chk("R2", "sel instance retried", drive_off, 1'b0);
        chk("R8", "nosel still off", ns_drive_off, 1'b1);
        chk("R8", "nosel fault_n", ns_fault_n, 1'b0);
        standby = 1'b1; tick(1);
        standby = 1'b0; tick(1);
        chk("R8", "nosel standby exit", ns_drive_off, 1'b0);
        chk("R8", "nosel fault cleared", ns_fault_n, 1'b1);
    endtask

    initial begin
        #(200_000 * 4);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        t_reset();
        t_thermal();
        t_uv();
        t_glitch();
        t_retry();
        t_requal();
        t_latch();
        t_por_clear();
        t_nosel();
        report();
    end

endmodule